// File: doc/BRIEF.md
# Page Write Load Controller

This block sits behind an asynchronous-style byte-wide memory bus and turns a burst of single-byte writes into one timed programming operation. The bus strobes arrive already synchronised to the block clock. Each write cycle deposits one byte into a page buffer. A write cycle is framed by chip-enable and write-enable, and output-enable must not be driving. The first byte of a burst fixes the page. Later bytes may land at any offset in that page, in any order, and any number of times.

Loading stays open while bytes keep coming. Once the bus has been quiet for a programmable number of cycles, the block raises `busy` and stops accepting strobes. It then emits only the loaded bytes, in ascending offset order, on a simple synchronous RAM write port. After that it holds `busy` for a programmable programming time, clears the buffer and returns to idle. A byte that names a different page from the one the burst opened on is discarded, and an error flag is raised.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy`, `cm_we` and `page_err` are low.
- R2: A write cycle starts only on the clock where `bus_ce_n` and `bus_we_n` are first seen both low while `bus_oe_n` is high. A strobe pair with `bus_oe_n` low, or with only one of the two strobes low, loads nothing.
- R3: The byte address is taken on the cycle the write starts, which is the later of the two strobe falls. The stored data is the value on `bus_din` during the last clock on which both strobes were still low.
- R4: The low `OFFS_W` address bits give the offset within the page and the remaining upper bits give the page. The commit address is `{page, offset}`.
- R5: Loading closes, and `busy` is first seen high, on the (LOAD_WIN+1)-th clock after the strobes are released with no further write cycle starting. A gap shorter than that keeps the same load open.
- R6: Bytes may be loaded in any offset order. A repeated offset keeps the data of its last write.
- R7: Only offsets loaded in the current burst are written to the RAM. Every other address is left untouched.
- R8: Commit strobes come on consecutive clocks, one per loaded byte, in strictly ascending offset order.
- R9: `busy` stays high for N+1+PROG_CYC clocks, where N is the number of distinct loaded offsets. `cm_we` is only ever high while `busy` is high.
- R10: A write whose page differs from the page of the burst's first byte is dropped, and `page_err` rises. `page_err` stays high until the next burst starts from idle.
- R11: Write cycles that begin while `busy` is high are ignored and reach no RAM location.
- R12: When programming ends, all loaded flags are cleared. The next burst commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Synchronised chip enable, active low |
| bus_we_n | input | 1 | Synchronised write enable, active low |
| bus_oe_n | input | 1 | Synchronised output enable, active low |
| bus_addr | input | ADDR_W | Byte address from the bus |
| bus_din | input | DATA_W | Write data from the bus |
| busy | output | 1 | High while committing and programming |
| page_err | output | 1 | A byte from a foreign page was dropped |
| cm_we | output | 1 | Commit write strobe to the RAM |
| cm_addr | output | ADDR_W | Commit address |
| cm_data | output | DATA_W | Commit data |

## Verification
The bench builds the block with a 9-bit address and 3 offset bits, which gives eight-byte pages, together with a 12-cycle load window and a 20-cycle programming time. These settings make the window expiry and a full programming period cheap to reach, so one run can cover several bursts. The small page lets the bench check, after each burst, that every neighbouring address in the page is untouched. It also lets the bench hit overwrites, out-of-order loads, a foreign-page drop and strobes issued mid-programming.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_PROG   = 2'd3
  } plc_phase_e;
endpackage

// File: rtl/plc_strobe.sv
// Frames one bus write cycle from the synchronised strobes.
module plc_strobe #(
  parameter int OFFS_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [OFFS_W-1:0] offs_in,
  input  logic [DATA_W-1:0] din,
  input  logic              accept,
  output logic              start_ev,
  output logic              end_ev,
  output logic              cyc_open,
  output logic [OFFS_W-1:0] cyc_offs,
  output logic [DATA_W-1:0] cyc_data
);
  logic wr_on, wr_on_q;
  logic [DATA_W-1:0] din_q;

  assign wr_on = !ce_n && !we_n;
  // R2: a fresh overlap of both strobes with output enable idle
  assign start_ev = accept && wr_on && oe_n && !wr_on_q && !cyc_open;
  // R3: the first strobe release closes the cycle
  assign end_ev   = cyc_open && !wr_on;
  assign cyc_data = din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_on_q  <= 1'b0;
      cyc_open <= 1'b0;
      cyc_offs <= '0;
      din_q    <= '0;
    end else begin
      wr_on_q <= wr_on;
      din_q   <= din;
      if (start_ev) begin
        cyc_open <= 1'b1;
        cyc_offs <= offs_in;
      end else if (end_ev) begin
        cyc_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/plc_page_buf.sv
// Page data store with one loaded flag per offset.
module plc_page_buf #(
  parameter int OFFS_W = 7,
  parameter int DATA_W = 8,
  localparam int PAGE  = 1 << OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFFS_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE-1:0]   valid
);
  logic [DATA_W-1:0] mem [PAGE];

  assign rd_data = mem[rd_off];

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OFFS_W'(g));

    always_ff @(posedge clk) begin
      if (hit) mem[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid[g] <= 1'b0;
      else if (clr) valid[g] <= 1'b0;   // R12
      else if (hit) valid[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/plc_seq.sv
// Phase sequencer: load window, ordered commit, programming timer.
module plc_seq
  import plc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int OFFS_W   = 7,
  parameter int LOAD_WIN = 37500,
  parameter int PROG_CYC = 2500000,
  localparam int PAGE    = 1 << OFFS_W,
  localparam int PAGE_W  = ADDR_W - OFFS_W,
  localparam int CNT_MAX = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              end_ev,
  input  logic              cyc_open,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [PAGE-1:0]   valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              accept,
  output logic              buf_wr,
  output logic              buf_clr,
  output logic [OFFS_W-1:0] rd_off,
  output logic              win_expire,
  output logic              prog_done,
  output logic              busy,
  output logic              page_err,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data
);
  plc_phase_e        ph;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page_q;
  logic              drop_q;
  logic [PAGE-1:0]   pending;
  logic              page_hit, commit_go;

  // R8: lowest pending offset goes next
  function automatic logic [OFFS_W-1:0] lowest_set(input logic [PAGE-1:0] m);
    logic [OFFS_W-1:0] r;
    r = '0;
    for (int i = PAGE - 1; i >= 0; i--) begin
      if (m[i]) r = OFFS_W'(i);
    end
    return r;
  endfunction

  assign accept     = (ph == PH_IDLE) || (ph == PH_LOAD);   // R11
  assign busy       = (ph == PH_COMMIT) || (ph == PH_PROG);
  assign page_hit   = (start_page == page_q);
  assign buf_wr     = (ph == PH_LOAD) && end_ev && !drop_q;
  // R5: window closes after LOAD_WIN quiet cycles
  assign win_expire = (ph == PH_LOAD) && !start_ev && !end_ev && !cyc_open &&
                      (cnt == CNT_W'(LOAD_WIN - 1));
  assign commit_go  = (ph == PH_COMMIT) && (pending != '0);
  // R9: programming timer end
  assign prog_done  = (ph == PH_PROG) && (cnt == CNT_W'(PROG_CYC - 1));
  assign buf_clr    = prog_done;
  assign rd_off     = lowest_set(pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      page_q   <= '0;
      drop_q   <= 1'b0;
      pending  <= '0;
      page_err <= 1'b0;
      cm_we    <= 1'b0;
      cm_addr  <= '0;
      cm_data  <= '0;
    end else begin
      cm_we <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start_ev) begin
            page_q   <= start_page;   // R4
            page_err <= 1'b0;         // R10
            drop_q   <= 1'b0;
            cnt      <= '0;
            ph       <= PH_LOAD;
          end
        end
        PH_LOAD: begin
          if (start_ev) begin
            drop_q <= !page_hit;      // R10
            if (!page_hit) page_err <= 1'b1;
            cnt <= '0;
          end else if (end_ev) begin
            cnt <= '0;
          end else if (!cyc_open) begin
            if (win_expire) begin
              ph      <= PH_COMMIT;
              pending <= valid;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_COMMIT: begin
          if (commit_go) begin
            cm_we           <= 1'b1;
            cm_addr         <= {page_q, rd_off};
            cm_data         <= rd_data;
            pending[rd_off] <= 1'b0;
          end else begin
            ph  <= PH_PROG;
            cnt <= '0;
          end
        end
        default: begin
          if (prog_done) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int OFFS_W   = 7,
  parameter int LOAD_WIN = 37500,
  parameter int PROG_CYC = 2500000,
  localparam int PAGE    = 1 << OFFS_W,
  localparam int PAGE_W  = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              busy,
  output logic              page_err,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data
);
  logic              start_ev, end_ev, cyc_open, accept;
  logic [OFFS_W-1:0] cyc_offs, rd_off;
  logic [DATA_W-1:0] cyc_data, rd_data;
  logic              buf_wr, buf_clr, win_expire, prog_done;
  logic [PAGE-1:0]   valid;

  plc_strobe #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
    .offs_in(bus_addr[OFFS_W-1:0]), .din(bus_din), .accept(accept),
    .start_ev(start_ev), .end_ev(end_ev), .cyc_open(cyc_open),
    .cyc_offs(cyc_offs), .cyc_data(cyc_data)
  );

  plc_page_buf #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_wr), .wr_off(cyc_offs), .wr_data(cyc_data),
    .clr(buf_clr), .rd_off(rd_off), .rd_data(rd_data), .valid(valid)
  );

  plc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_ev(start_ev), .end_ev(end_ev), .cyc_open(cyc_open),
    .start_page(bus_addr[ADDR_W-1:OFFS_W]),
    .valid(valid), .rd_data(rd_data),
    .accept(accept), .buf_wr(buf_wr), .buf_clr(buf_clr), .rd_off(rd_off),
    .win_expire(win_expire), .prog_done(prog_done),
    .busy(busy), .page_err(page_err),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data)
  );
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int ADDR_W   = 17,
  parameter int OFFS_W   = 7,
  localparam int PAGE    = 1 << OFFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              page_err,
  input logic              cm_we,
  input logic [ADDR_W-1:0] cm_addr,
  input logic              start_ev,
  input logic              end_ev,
  input logic              win_expire,
  input logic              prog_done,
  input logic [PAGE-1:0]   valid
);
  // R11
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ev);
  // R5
  window_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> busy);
  // R12
  clear_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (!busy && valid == '0));
  // R7
  commit_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |-> valid[cm_addr[OFFS_W-1:0]]);
  // R8
  commit_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_we && $past(cm_we)) |-> (cm_addr[OFFS_W-1:0] > $past(cm_addr[OFFS_W-1:0])));
  // R10
  err_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(start_ev));
  // R2
  cycle_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, end_ev}));
  // R9
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |-> busy);
endmodule

bind page_load_ctrl plc_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
  .cm_we(cm_we), .cm_addr(cm_addr), .start_ev(start_ev), .end_ev(end_ev),
  .win_expire(win_expire), .prog_done(prog_done), .valid(valid)
);

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
  localparam int AW   = 9;
  localparam int OW   = 3;
  localparam int LW   = 12;
  localparam int PC   = 20;
  localparam int PAGE = 1 << OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic busy, page_err, cm_we;
  logic [AW-1:0] cm_addr;
  logic [7:0] cm_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] ram [1 << AW];
  int log_a[$];
  int log_t[$];

  always #2 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(8), .OFFS_W(OW), .LOAD_WIN(LW), .PROG_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_din(din), .busy(busy), .page_err(page_err),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  function automatic logic [7:0] seed_val(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ram(input int a, input int exp, input string req);
    chk(ram[a] == 8'(exp), req, $sformatf("ram[%0d]", a), ram[a], exp);
  endtask

  // behavioural reference, advanced at every rising edge
  int  m_phase = 0, m_cnt = 0, m_page = 0;
  bit  m_wrq = 0, m_inc = 0, m_drop = 0;
  int  m_coff = 0;
  int  m_din = 0;
  int  m_data [PAGE];
  bit  m_val [PAGE];
  int  m_q[$];
  bit  e_we = 0, e_err = 0;
  int  e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_wrq = 0; m_inc = 0; m_drop = 0;
      e_we = 0; e_err = 0; m_din = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else begin
      bit won, acc, st, en;
      won = !ce_n && !we_n;
      acc = (m_phase < 2);
      st  = acc && won && oe_n && !m_wrq && !m_inc;
      en  = m_inc && !won;
      e_we = 0;
      case (m_phase)
        0: if (st) begin
             m_page = int'(addr) / PAGE; e_err = 0; m_drop = 0; m_cnt = 0; m_phase = 1;
           end
        1: if (st) begin
             m_drop = (int'(addr) / PAGE) != m_page;
             if (m_drop) e_err = 1;
             m_cnt = 0;
           end else if (en) begin
             if (!m_drop) begin m_data[m_coff] = m_din; m_val[m_coff] = 1; end
             m_cnt = 0;
           end else if (!m_inc) begin
             if (m_cnt == LW - 1) begin
               m_phase = 2; m_cnt = 0;
               for (int i = 0; i < PAGE; i++) if (m_val[i]) m_q.push_back(i);
             end else m_cnt++;
           end
        2: if (m_q.size() > 0) begin
             int o;
             o = m_q.pop_front();
             e_we = 1; e_addr = m_page * PAGE + o; e_data = m_data[o];
           end else begin
             m_phase = 3; m_cnt = 0;
           end
        default: if (m_cnt == PC - 1) begin
             m_phase = 0; m_cnt = 0;
             foreach (m_val[i]) m_val[i] = 0;
           end else m_cnt++;
      endcase
      if (st) begin m_inc = 1; m_coff = int'(addr) % PAGE; end
      else if (en) m_inc = 0;
      m_wrq = won;
      m_din = int'(din);
    end
  end

  // RAM model, per-clock comparison and commit log
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_phase >= 2), "R9", "busy vs model", busy, m_phase >= 2);
      chk(cm_we == e_we, "R8", "cm_we vs model", cm_we, e_we);
      chk(page_err == e_err, "R10", "page_err vs model", page_err, e_err);
      if (e_we && cm_we) begin
        chk(int'(cm_addr) == e_addr, "R4", "cm_addr vs model", cm_addr, e_addr);
        chk(int'(cm_data) == e_data, "R6", "cm_data vs model", cm_data, e_data);
      end
    end
    if (cm_we) begin
      ram[cm_addr] = cm_data;
      log_a.push_back(int'(cm_addr));
      log_t.push_back(cyc);
    end
  end

  task automatic wr(input int a, input int d, input int low = 1, input int gap = 2);
    @(negedge clk);
    addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0;
    repeat (low) @(negedge clk);
    ce_n = 1; we_n = 1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ram[i] = seed_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(cm_we == 0, "R1", "cm_we after reset", cm_we, 0);
    chk(page_err == 0, "R1", "page_err after reset", page_err, 0);

    // R4 single byte
    wr(1 * PAGE + 3, 8'hA5);
    wait_done();
    chk_ram(11, 8'hA5, "R4");
    chk_ram(10, seed_val(10), "R7");

    // R6 R7 R8 R9 out of order with overwrite
    log_a.delete(); log_t.delete();
    wr(16 + 6, 11); wr(16 + 1, 22); wr(16 + 4, 33); wr(16 + 1, 44);
    begin
      int len;
      len = 0;
      while (!busy) @(negedge clk);
      while (busy) begin len++; @(negedge clk); end
      chk(len == 3 + 1 + PC, "R9", "busy length", len, 3 + 1 + PC);
    end
    chk_ram(22, 11, "R6");
    chk_ram(17, 44, "R6");
    chk_ram(20, 33, "R6");
    for (int o = 0; o < PAGE; o++)
      if (o != 1 && o != 4 && o != 6) chk_ram(16 + o, seed_val(16 + o), "R7");
    chk(log_a.size() == 3, "R8", "commit count", log_a.size(), 3);
    if (log_a.size() == 3) begin
      chk(log_a[0] == 17 && log_a[1] == 20 && log_a[2] == 22, "R8", "commit order first", log_a[0], 17);
      chk(log_t[2] - log_t[0] == 2, "R8", "commit spacing", log_t[2] - log_t[0], 2);
    end

    // R2 inhibited strobes
    @(negedge clk); addr = 40; din = 8'h99; oe_n = 0; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk); we_n = 0; addr = 42;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (LW + 5) @(negedge clk);
    chk(busy == 0, "R2", "no load started", busy, 0);
    wr(41, 8'h77);
    wait_done();
    chk_ram(40, seed_val(40), "R2");
    chk_ram(42, seed_val(42), "R2");
    chk_ram(41, 8'h77, "R2");

    // R3 later fall gives address, last low cycle gives data
    @(negedge clk); we_n = 0; ce_n = 1; addr = 50; din = 8'hF0;
    @(negedge clk); addr = 52; ce_n = 0; din = 1;
    @(negedge clk); din = 2;
    @(negedge clk); din = 3;
    @(negedge clk); ce_n = 1; din = 9;
    @(negedge clk); we_n = 1;
    wait_done();
    chk_ram(52, 3, "R3");
    chk_ram(50, seed_val(50), "R3");

    // R10 foreign page dropped
    wr(24, 8'h10); wr(34, 8'h20);
    chk(page_err == 1, "R10", "page_err raised", page_err, 1);
    wait_done();
    chk_ram(24, 8'h10, "R10");
    chk_ram(34, seed_val(34), "R10");
    chk(page_err == 1, "R10", "page_err held", page_err, 1);

    // R11 strobes during busy, R12 flags cleared
    wr(57, 8'h5E);
    while (!busy) @(negedge clk);
    wr(58, 8'h6E);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk_ram(58, seed_val(58), "R11");
    chk_ram(57, 8'h5E, "R11");
    log_a.delete(); log_t.delete();
    wr(59, 8'h7E);
    chk(page_err == 0, "R10", "page_err cleared by new burst", page_err, 0);
    wait_done();
    chk(log_a.size() == 1, "R12", "only new byte committed", log_a.size(), 1);
    chk_ram(59, 8'h7E, "R12");
    chk_ram(58, seed_val(58), "R11");

    // R5 window: short gaps keep one load, then exact close
    log_a.delete(); log_t.delete();
    wr(64, 1, 1, LW - 4);
    chk(busy == 0, "R5", "open after short gap", busy, 0);
    wr(65, 2, 2, LW - 4);
    chk(busy == 0, "R5", "open after second gap", busy, 0);
    @(negedge clk); addr = 66; din = 3; ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1;
    begin
      int k;
      k = 0;
      while (!busy && k < 4 * LW) begin @(negedge clk); k++; end
      chk(k == LW + 1, "R5", "cycles to close", k, LW + 1);
    end
    wait_done();
    chk(log_a.size() == 3, "R5", "single load commit count", log_a.size(), 3);
    chk_ram(64, 1, "R5");
    chk_ram(66, 3, "R5");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule